// File: doc/BRIEF.md
# Burst Physical Memory Access Engine

This block gives a host burst access to a shared pixel memory at physical addresses. The host writes a stream of words into an input queue: a command word first, then a physical start address, then the data words for a write. Words read from memory come back to the host through an output queue. Toward the memory, the block drives a simple request/grant port. Every cycle in which both request and grant are high moves one word.

Four programmable fill levels govern the traffic. On each queue, a MAX level decides when transfers stop. On the input side, the host is held off once the fill reaches MAX. On the output side, memory reads pause once the fill reaches MAX. A MIN level on each queue sets the length of each memory burst. Bigger bursts waste fewer launch cycles, but they hold the memory longer. The address advances by one after every word, so one start address covers a whole command of up to 65535 words.

Top module: `burst_access_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `mem_req` is 0.
- R2: A command word carries its opcode in bits [31:30] and its word count in bits [15:0]. Opcode 01 is a write and opcode 10 is a read. The next queue word is the start address, taken from its low AW bits. A word with opcode 00 or 11, where a command is expected, is discarded and has no other effect.
- R3: A write stores its data words, in order, at consecutive addresses from the start address. A read returns the words from consecutive addresses, in order. The address rises by one after each transferred word.
- R4: A command with a word count of 0 finishes after its address word and makes no memory request.
- R5: A write burst starts only when the input queue holds at least L words, where L = min(remaining count, effective input MIN). The burst then moves L words back to back while the grant stays high.
- R6: The input queue accepts a host word only while its fill is below the effective input MAX and it is not full.
- R7: A read burst starts only when the output queue has room for L = min(remaining count, effective output MIN) words and its fill is below the effective output MAX. Read requests pause while the fill is at or above the output MAX, and resume once it drops below.
- R8: `mem_req` is never high while `mem_gnt` is low. If the grant drops, the burst ends on a word boundary. The next address and the remaining count are kept, and the transfer continues when the grant returns.
- R9: Register select 0 is input MIN, 1 is input MAX, 2 is output MIN and 3 is output MAX. Reset values are MIN = 4 and MAX = DEPTH. A MAX of 0 acts as 1, and a MAX above DEPTH acts as DEPTH. A MIN of 0 acts as 1, and a MIN above its MAX acts as that MAX.
- R10: A fill level written while a burst is in progress takes effect only once that burst has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a word to the input queue |
| in_data | input | DW | Command, address or write data word |
| in_ready | output | 1 | Input queue accepts a word this cycle |
| out_valid | output | 1 | Output queue holds read data |
| out_data | output | DW | Oldest read data word |
| out_ready | input | 1 | Host takes the output word |
| cfg_we | input | 1 | Fill-level register write strobe |
| cfg_sel | input | 2 | Fill-level register select |
| cfg_wdata | input | FILL_W | Fill-level value |
| mem_req | output | 1 | Word transfer request toward the arbiter |
| mem_gnt | input | 1 | Arbiter grant |
| mem_we | output | 1 | 1 for write transfers, 0 for reads |
| mem_addr | output | AW | Physical word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in a granted read cycle |

## Verification
Two things can fall in the same cycle and must be judged together. A host pop from the output queue can coincide with the read beat that refills it. A fill-level register write can coincide with a burst that is stalled at output MAX. The bench parks a read at the output MAX with no pops and counts granted read beats. It then writes a larger MAX while the burst is stalled and checks that the beat count does not move. Next it drains the queue word by word, so each pop releases a beat in that same cycle, and checks every returned word. A later read must then stop at the new MAX. Random grant patterns also interrupt bursts at arbitrary beats, and all read data is compared against a model memory kept by the bench.

// File: rtl/bae_pkg.sv
`timescale 1ns/1ps
package bae_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_BURST = 2'd3
  } bae_state_e;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  // MAX level as used: zero acts as one, anything above the depth as the depth
  function automatic int unsigned eff_max(int unsigned raw, int unsigned depth);
    if (raw == 0) return 1;
    if (raw > depth) return depth;
    return raw;
  endfunction

  // MIN level as used: at least one, never above the matching MAX
  function automatic int unsigned eff_min(int unsigned raw, int unsigned maxv);
    int unsigned r;
    r = (raw == 0) ? 1 : raw;
    return (r > maxv) ? maxv : r;
  endfunction

  // words in the next burst
  function automatic int unsigned chunk_len(int unsigned remaining, int unsigned minv);
    return (remaining < minv) ? remaining : minv;
  endfunction

endpackage

// File: rtl/bae_fifo.sv
`timescale 1ns/1ps
module bae_fifo #(
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DW-1:0]     wdata,
  input  logic              pop,
  output logic [DW-1:0]     rdata,
  output logic [FILL_W-1:0] count,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DW-1:0]    store [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + PTR_W'(1);
      if (pop)  rp <= rp + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + FILL_W'(1);
        2'b01:   count <= count - FILL_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdata = store[rp];
  assign full  = (count == FILL_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/bae_levels.sv
`timescale 1ns/1ps
module bae_levels
  import bae_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int MIN_RST = 4,
  parameter int FILL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [FILL_W-1:0] cfg_wdata,
  input  logic              hold,
  output logic [FILL_W-1:0] in_min_e,
  output logic [FILL_W-1:0] in_max_e,
  output logic [FILL_W-1:0] out_min_e,
  output logic [FILL_W-1:0] out_max_e
);
  localparam int NREG = 4;

  logic [FILL_W-1:0] pend [NREG];
  logic [FILL_W-1:0] live [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        pend[i] <= i[0] ? FILL_W'(DEPTH) : FILL_W'(MIN_RST);
        live[i] <= i[0] ? FILL_W'(DEPTH) : FILL_W'(MIN_RST);
      end
    end else begin
      if (cfg_we) pend[cfg_sel] <= cfg_wdata;
      if (!hold) begin
        for (int i = 0; i < NREG; i++) live[i] <= pend[i];
      end
    end
  end

  always_comb begin
    in_max_e  = FILL_W'(eff_max(32'(live[1]), DEPTH));
    out_max_e = FILL_W'(eff_max(32'(live[3]), DEPTH));
    in_min_e  = FILL_W'(eff_min(32'(live[0]), 32'(in_max_e)));
    out_min_e = FILL_W'(eff_min(32'(live[2]), 32'(out_max_e)));
  end

endmodule

// File: rtl/bae_sequencer.sv
`timescale 1ns/1ps
module bae_sequencer
  import bae_pkg::*;
#(
  parameter int AW     = 24,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 16,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_empty,
  input  logic [FILL_W-1:0] in_count,
  input  logic [1:0]        head_op,
  input  logic [CNT_W-1:0]  head_cnt,
  input  logic [AW-1:0]     head_addr,
  input  logic [FILL_W-1:0] out_count,
  input  logic [FILL_W-1:0] in_min_e,
  input  logic [FILL_W-1:0] out_min_e,
  input  logic [FILL_W-1:0] out_max_e,
  input  logic              mem_gnt,
  output logic              in_pop,
  output logic              out_push,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     cur_addr,
  output logic              busy,
  output logic              beat
);
  bae_state_e        state;
  logic              is_read;
  logic [CNT_W-1:0]  rem;
  logic [FILL_W-1:0] beats_left;

  logic [FILL_W-1:0] len_w, len_r, len, out_free;
  logic              start_ok, launch, pause, op_ok;

  always_comb begin
    len_w    = FILL_W'(chunk_len(32'(rem), 32'(in_min_e)));
    len_r    = FILL_W'(chunk_len(32'(rem), 32'(out_min_e)));
    len      = is_read ? len_r : len_w;
    out_free = FILL_W'(DEPTH) - out_count;
    start_ok = is_read ? ((out_free >= len) && (out_count < out_max_e))
                       : (in_count >= len);
    launch   = (state == ST_WAIT) && mem_gnt && start_ok;
    pause    = is_read && (out_count >= out_max_e);
    op_ok    = (head_op == OP_WR) || (head_op == OP_RD);
  end

  assign busy     = (state == ST_BURST);
  assign mem_req  = busy && mem_gnt && !pause;
  assign beat     = mem_req;
  assign mem_we   = !is_read;
  assign out_push = beat && is_read;
  assign in_pop   = (((state == ST_IDLE) || (state == ST_ADDR)) && !in_empty)
                  || (beat && !is_read);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      is_read    <= 1'b0;
      rem        <= '0;
      cur_addr   <= '0;
      beats_left <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!in_empty && op_ok) begin
            is_read <= (head_op == OP_RD);
            rem     <= head_cnt;
            state   <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (!in_empty) begin
            cur_addr <= head_addr;
            state    <= (rem == '0) ? ST_IDLE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (launch) begin
            beats_left <= len;
            state      <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (!mem_gnt) begin
            state <= ST_WAIT;
          end else if (beat) begin
            cur_addr   <= cur_addr + AW'(1);
            rem        <= rem - CNT_W'(1);
            beats_left <= beats_left - FILL_W'(1);
            if (beats_left == FILL_W'(1)) begin
              state <= (rem == CNT_W'(1)) ? ST_IDLE : ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/burst_access_engine.sv
`timescale 1ns/1ps
module burst_access_engine
  import bae_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 24,
  parameter int CNT_W   = 16,
  parameter int DEPTH   = 16,
  parameter int MIN_RST = 4,
  parameter int FILL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  input  logic              out_ready,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [FILL_W-1:0] cfg_wdata,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  logic [DW-1:0]     in_head;
  logic [FILL_W-1:0] in_count, out_count;
  logic              in_full, in_empty, out_full, out_empty;
  logic              in_push, in_pop, out_push, out_pop;
  logic              busy, beat;
  logic [AW-1:0]     cur_addr;
  logic [FILL_W-1:0] in_min_e, in_max_e, out_min_e, out_max_e;

  assign in_ready = !in_full && (in_count < in_max_e);
  assign in_push  = in_valid && in_ready;
  assign out_pop  = out_ready && !out_empty;
  assign out_valid = !out_empty;

  bae_fifo #(.DW(DW), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_in_q (
    .clk(clk), .rst_n(rst_n), .push(in_push), .wdata(in_data), .pop(in_pop),
    .rdata(in_head), .count(in_count), .full(in_full), .empty(in_empty)
  );

  bae_fifo #(.DW(DW), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_out_q (
    .clk(clk), .rst_n(rst_n), .push(out_push), .wdata(mem_rdata), .pop(out_pop),
    .rdata(out_data), .count(out_count), .full(out_full), .empty(out_empty)
  );

  bae_levels #(.DEPTH(DEPTH), .MIN_RST(MIN_RST), .FILL_W(FILL_W)) u_levels (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hold(busy),
    .in_min_e(in_min_e), .in_max_e(in_max_e),
    .out_min_e(out_min_e), .out_max_e(out_max_e)
  );

  bae_sequencer #(.AW(AW), .CNT_W(CNT_W), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_empty(in_empty), .in_count(in_count),
    .head_op(in_head[DW-1 -: 2]), .head_cnt(in_head[CNT_W-1:0]),
    .head_addr(in_head[AW-1:0]),
    .out_count(out_count), .in_min_e(in_min_e),
    .out_min_e(out_min_e), .out_max_e(out_max_e),
    .mem_gnt(mem_gnt), .in_pop(in_pop), .out_push(out_push),
    .mem_req(mem_req), .mem_we(mem_we), .cur_addr(cur_addr),
    .busy(busy), .beat(beat)
  );

  assign mem_addr  = cur_addr;
  assign mem_wdata = in_head;

endmodule

// File: rtl/bae_checker.sv
`timescale 1ns/1ps
module bae_checker #(
  parameter int AW     = 24,
  parameter int FILL_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mem_req,
  input logic                mem_gnt,
  input logic                mem_we,
  input logic                beat,
  input logic                busy,
  input logic [AW-1:0]       cur_addr,
  input logic                in_push,
  input logic                in_full,
  input logic [FILL_W-1:0]   in_count,
  input logic [FILL_W-1:0]   in_max_e,
  input logic                out_push,
  input logic                out_full,
  input logic [FILL_W-1:0]   out_count,
  input logic [FILL_W-1:0]   out_max_e,
  input logic [4*FILL_W-1:0] thr_bus
);

  a_r8_req_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_gnt);

  a_r8_req_only_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (cur_addr == AW'($past(cur_addr) + AW'(1))));

  a_r7_pause_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (out_count < out_max_e));

  a_r7_no_out_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> !out_full);

  a_r6_no_in_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    in_push |-> !in_full);

  a_r6_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
    in_push |-> (in_count < in_max_e));

  a_r10_levels_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(thr_bus));

endmodule

bind burst_access_engine bae_checker #(.AW(AW), .FILL_W(FILL_W)) u_bae_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_we(mem_we), .beat(beat), .busy(busy), .cur_addr(cur_addr),
  .in_push(in_push), .in_full(in_full), .in_count(in_count),
  .in_max_e(in_max_e), .out_push(out_push), .out_full(out_full),
  .out_count(out_count), .out_max_e(out_max_e),
  .thr_bus({in_min_e, in_max_e, out_min_e, out_max_e})
);

// File: tb/burst_access_engine_bench.sv
`timescale 1ns/1ps
module burst_access_engine_bench;
  localparam int DW = 32, AW = 24, DEPTH = 16;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, cfg_we = 1'b0, mem_gnt = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [1:0] cfg_sel = '0;
  logic [FILL_W-1:0] cfg_wdata = '0;
  logic in_ready, out_valid, mem_req, mem_we;
  logic [DW-1:0] out_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  logic [31:0] mem_model [256];
  logic [31:0] exp_mem [256];
  int checks = 0, fails = 0, cyc = 0;
  int wbeats = 0, rbeats = 0, run = 0, max_run = 0;
  int gnt_mode = 0;

  always #4 clk = ~clk;

  burst_access_engine u_burst_access_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem_model[mem_addr[7:0]];

  always @(negedge clk) begin
    case (gnt_mode)
      0: mem_gnt <= 1'b0;
      1: mem_gnt <= 1'b1;
      default: mem_gnt <= ($urandom % 5) != 0;
    endcase
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n && mem_req && mem_gnt) begin
      if (mem_we) begin
        mem_model[mem_addr[7:0]] = mem_wdata;
        wbeats = wbeats + 1;
      end else begin
        rbeats = rbeats + 1;
      end
    end
    if (rst_n && mem_req && mem_gnt && mem_we) run = run + 1;
    else run = 0;
    if (run > max_run) max_run = run;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R8 watchdog: cycles %0d expected below %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // all tasks start and end just after a falling edge
  task automatic push(input logic [31:0] w);
    in_data = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cfg(input int sel, input int val);
    cfg_sel = 2'(sel);
    cfg_wdata = FILL_W'(val);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] cmd_word(input bit rd, input int cnt);
    return {rd ? 2'b10 : 2'b01, 14'd0, 16'(cnt)};
  endfunction

  task automatic put_data(input int base, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      logic [31:0] d;
      d = $urandom;
      exp_mem[(base + i) & 255] = d;
      push(d);
    end
  endtask

  task automatic pop_check(input logic [31:0] exp, input string tag);
    logic [31:0] got;
    while (!out_valid) @(negedge clk);
    got = out_data;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(got == exp, tag, got, exp);
  endtask

  task automatic read_back(input int base, input int n, input string tag);
    push(cmd_word(1'b1, n));
    push(32'(base));
    for (int i = 0; i < n; i++) pop_check(exp_mem[(base + i) & 255], tag);
  endtask

  initial begin
    int wb0, rb0, acc;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem_model[i] = '0;
      exp_mem[i] = '0;
    end
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);

    // R5: write burst waits for MIN words, then runs MIN back to back
    gnt_mode = 1;
    cfg(0, 8);
    idle(3);
    wb0 = wbeats;
    push(cmd_word(1'b0, 10));
    push(32'h40);
    put_data(32'h40, 0, 3);
    idle(20);
    chk(wbeats - wb0 == 0, "R5 hold below MIN", wbeats - wb0, 0);
    max_run = 0;
    put_data(32'h40, 3, 7);
    idle(30);
    chk(wbeats - wb0 == 10, "R5 total beats", wbeats - wb0, 10);
    chk(max_run == 8, "R5 burst length", max_run, 8);
    cfg(0, 4);

    // R7 / R10: read stalls at output MAX; a MAX write during the stall is deferred
    cfg(2, 3);
    cfg(3, 4);
    idle(3);
    rb0 = rbeats;
    push(cmd_word(1'b1, 10));
    push(32'h40);
    idle(30);
    chk(rbeats - rb0 == 4, "R7 pause at MAX", rbeats - rb0, 4);
    cfg(3, 8);
    idle(20);
    chk(rbeats - rb0 == 4, "R10 deferred level", rbeats - rb0, 4);
    for (int i = 0; i < 10; i++) pop_check(exp_mem[(32'h40 + i) & 255], "R3 read order");
    idle(10);
    rb0 = rbeats;
    push(cmd_word(1'b1, 10));
    push(32'h40);
    idle(40);
    chk(rbeats - rb0 == 8, "R10 level applied after burst", rbeats - rb0, 8);
    for (int i = 0; i < 10; i++) pop_check(exp_mem[(32'h40 + i) & 255], "R7 resume data");
    cfg(2, 4);
    cfg(3, 16);

    // R4: zero-length command
    idle(5);
    wb0 = wbeats;
    push(cmd_word(1'b0, 0));
    push(32'h10);
    idle(10);
    chk(wbeats == wb0, "R4 no request", wbeats - wb0, 0);

    // R2: invalid opcodes dropped
    push(32'h0000_0005);
    push(32'hC000_0003);
    read_back(32'h40, 2, "R2 after dropped words");
    idle(5);
    chk(out_valid == 1'b0, "R2 no extra output", out_valid, 0);

    // R6 / R9: input MAX limits host; clamped MIN lets the write finish
    cfg(1, 3);
    idle(3);
    gnt_mode = 0;
    push(cmd_word(1'b0, 20));
    push(32'h80);
    acc = 0;
    for (int k = 0; k < 20; k++) begin
      logic [31:0] d;
      d = 32'hA500_0000 + 32'(acc);
      in_data = d;
      in_valid = 1'b1;
      if (in_ready) begin
        exp_mem[(32'h80 + acc) & 255] = d;
        acc++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(acc == 3, "R6 accepted up to MAX", acc, 3);
    gnt_mode = 2;
    put_data(32'h80, acc, 20 - acc);
    read_back(32'h80, 20, "R9 MIN clamped to MAX");
    cfg(1, 16);

    // R9: MAX of zero acts as one
    cfg(1, 0);
    idle(3);
    gnt_mode = 0;
    push(cmd_word(1'b0, 3));
    push(32'hA0);
    acc = 0;
    for (int k = 0; k < 10; k++) begin
      logic [31:0] d;
      d = 32'h5A00_0000 + 32'(acc);
      in_data = d;
      in_valid = 1'b1;
      if (in_ready) begin
        exp_mem[(32'hA0 + acc) & 255] = d;
        acc++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(acc == 1, "R9 zero MAX acts as one", acc, 1);
    cfg(1, 16);
    gnt_mode = 2;
    put_data(32'hA0, acc, 3 - acc);
    read_back(32'hA0, 3, "R9 data");

    // R8 / R3: random commands, levels and grant gaps
    for (int it = 0; it < 30; it++) begin
      int base, n;
      cfg(0, $urandom % 20);
      cfg(1, $urandom % 20);
      cfg(2, $urandom % 20);
      cfg(3, $urandom % 20);
      base = $urandom % 256;
      n = 1 + ($urandom % 24);
      if ($urandom % 2) begin
        push(cmd_word(1'b0, n));
        push(32'(base));
        put_data(base, 0, n);
      end else begin
        idle($urandom % 8);
        read_back(base, n, "R8 random grant read");
      end
    end
    for (int i = 0; i < 8; i++) read_back(i * 32, 16, "R3 final sweep");

    idle(20);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule